// File: doc/BRIEF.md
# Lockable Flash Write-Protect Range Unit

This unit sits beside the command path of a serial NOR flash controller. It holds a small set of protected windows, each a run of whole 4 KiB blocks. For every outgoing command it raises a block flag when the command would modify the flash inside one of those windows. Software configures it through a request/response port. The configuration covers a base address that can be written only once, an erase opcode, a status-write prefix opcode, range allocation, a wipe of all ranges, and a sticky lock. The lock freezes all configuration until reset.

The request port uses valid/ready. A request is taken on a rising edge where `cfg_valid` and `cfg_ready` are both high. One cycle later a response with a 3-bit status appears on `rsp_valid`/`rsp_status`. That response stays until `rsp_ready` is seen high. `cfg_ready` is low only while an earlier response is still waiting, so a stalled consumer stalls the producer. No request is ever lost and none is ever answered twice. A separate coverage query takes a block span and, one cycle later, reports whether the union of valid ranges covers every block of that span. The depth of the range set, the largest window and the highest allowed base are parameters, and the unit reports them on constant outputs.

Top module: `wpr_unit`

## Requirements
- R1: A request is accepted on an edge where `cfg_valid && cfg_ready`. The following cycle shows `rsp_valid=1` with its status. While `rsp_valid && !rsp_ready`, the response and its status hold and `cfg_ready` is 0. Otherwise `cfg_ready` is 1.
- R2: `cfg_op` encodings: 0 load erase opcode from `cfg_arg[7:0]`, 1 load prefix opcode from `cfg_arg[7:0]`, 2 set base to `cfg_arg`, 3 wipe all ranges, 4 allocate a range, 5 lock. Codes 6 and 7 answer status 2. Status encodings: 0 ok, 1 access refused, 2 bad argument, 3 not allowed now, 4 no free range, 5 already locked.
- R3: The first lock answers 0 and raises `locked`. Every later lock answers 5 and changes nothing. `locked` falls only on reset.
- R4: While locked, ops 0 to 4 answer 1 and leave the opcodes, the base and all ranges unchanged.
- R5: Setting the base answers 2 if `cfg_arg` exceeds MAX_OFFSET, and the base stays unset. Otherwise the first set answers 0, raises `base_set` and drives `base_addr`. Any later set answers 3 and keeps the old base.
- R6: Allocation before the base is set answers 3.
- R7: Allocation answers 2 in any of three cases: start `cfg_arg` below the base, `cfg_count`×4096 above MAX_RANGE, or (start − base + `cfg_count`×4096) above MAX_RANGE.
- R8: A valid allocation fills the next free register, starting from the first, and answers 0. When all NR are in use it answers 4. A range covers blocks `cfg_arg>>12` up to, but not including, `(cfg_arg>>12)+cfg_count`. The bad-argument check comes before the full check.
- R9: A wipe (op 3, unlocked) answers 0, invalidates every range and frees all registers.
- R10: `chk_block` is high, in the same cycle, when the command modifies the flash and block `chk_addr>>12` lies in a valid range. A command modifies the flash when `chk_write=1`, or when the erase opcode has been loaded and `chk_opcode` equals it.
- R11: A read command is never blocked. A read has `chk_write=0` and an opcode other than the loaded erase opcode.
- R12: A query with `q_valid` gives `q_rsp_valid=1` one cycle later. `q_protected` is 1 only when `q_count≠0` and every block from `q_addr>>12` up to `(q_addr>>12)+q_count`, end excluded, lies in some valid range.
- R13: `cap_ranges`, `cap_max_range` and `cap_max_offset` equal NR, MAX_RANGE and MAX_OFFSET.
- R14: After reset: no response pending, `cfg_ready=1`, unlocked, base unset, no range valid, no query response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration request valid |
| cfg_ready | output | 1 | Request can be taken |
| cfg_op | input | 3 | Operation code |
| cfg_arg | input | AW | Address or opcode argument |
| cfg_count | input | CW | Block count for allocation |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_status | output | 3 | Response status |
| locked | output | 1 | Configuration frozen |
| base_set | output | 1 | Base has been written |
| base_addr | output | AW | Current base address |
| erase_set | output | 1 | Erase opcode loaded |
| erase_opcode | output | 8 | Loaded erase opcode |
| prefix_opcode | output | 8 | Loaded status-write prefix opcode |
| chk_opcode | input | 8 | Opcode of the command under check |
| chk_write | input | 1 | Command is a program/erase class |
| chk_addr | input | AW | Target address of the command |
| chk_block | output | 1 | Command must be suppressed |
| q_valid | input | 1 | Coverage query valid |
| q_addr | input | AW | Query start address |
| q_count | input | CW | Query length in blocks |
| q_rsp_valid | output | 1 | Query answer valid |
| q_protected | output | 1 | Whole span covered |
| cap_ranges | output | 8 | Number of range registers |
| cap_max_range | output | 32 | Largest window in bytes |
| cap_max_offset | output | 32 | Highest allowed base |

## Verification
The properties assume that a producer drops `cfg_valid` or keeps it stable once a request is taken. They also assume `cfg_count` fits the block index, so a window end never wraps past the top of the address space. The stimulus drives each request for exactly one accepting edge and then lowers valid. Counts stay within 8 bits against a 20-bit block index. The coverage and check sweeps use addresses well below the top of the space, so the end-of-range sums in the bench match the hardware widths.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  localparam int unsigned BLK_SHIFT = 12;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_ACCESS  = 3'd1,
    ST_INVALID = 3'd2,
    ST_UNSUP   = 3'd3,
    ST_NORES   = 3'd4,
    ST_ALREADY = 3'd5
  } wpr_status_e;

  typedef enum logic [2:0] {
    OP_ERASE_OP  = 3'd0,
    OP_PREFIX_OP = 3'd1,
    OP_BASE      = 3'd2,
    OP_CLEAR     = 3'd3,
    OP_PROTECT   = 3'd4,
    OP_LOCK      = 3'd5
  } wpr_op_e;
endpackage

// File: rtl/wpr_ctrl.sv
module wpr_ctrl
  import wpr_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned CW         = 16,
  parameter int unsigned NR         = 5,
  parameter int unsigned MAX_RANGE  = 32'h0100_0000,
  parameter int unsigned MAX_OFFSET = 32'h0100_0000,
  localparam int unsigned BW = AW - BLK_SHIFT,
  localparam int unsigned EW = BW + 1,
  localparam int unsigned IW = $clog2(NR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_valid,
  output logic          cfg_ready,
  input  logic [2:0]    cfg_op,
  input  logic [AW-1:0] cfg_arg,
  input  logic [CW-1:0] cfg_count,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [2:0]    rsp_status,
  output logic          locked,
  output logic          base_set,
  output logic [AW-1:0] base_addr,
  output logic          erase_set,
  output logic [7:0]    erase_opcode,
  output logic [7:0]    prefix_opcode,
  output logic          rng_we,
  output logic [IW-1:0] rng_idx,
  output logic [EW-1:0] rng_start,
  output logic [EW-1:0] rng_end,
  output logic          rng_clr
);
  localparam int unsigned SW = AW + CW + BLK_SHIFT + 1;

  logic          acc;
  logic          full;
  logic          bad_rng;
  logic [SW-1:0] span;
  logic [SW-1:0] off;
  logic [SW-1:0] reach;
  logic [IW-1:0] nxt_q;
  wpr_status_e   st;

  assign cfg_ready = !rsp_valid || rsp_ready;
  assign acc       = cfg_valid && cfg_ready;
  assign full      = (nxt_q == IW'(NR));

  // window bound arithmetic, kept wide enough that no sum wraps
  always_comb begin
    span    = SW'(cfg_count) << BLK_SHIFT;
    off     = SW'(cfg_arg) - SW'(base_addr);
    reach   = off + span;
    bad_rng = (cfg_arg < base_addr) || (span > SW'(MAX_RANGE)) ||
              (reach > SW'(MAX_RANGE));
  end

  // lock refusal first, then ordering rules, then argument checks
  always_comb begin
    case (cfg_op)
      OP_ERASE_OP, OP_PREFIX_OP, OP_CLEAR:
        st = locked ? ST_ACCESS : ST_OK;
      OP_BASE:
        if (locked)                        st = ST_ACCESS;
        else if (base_set)                 st = ST_UNSUP;
        else if (SW'(cfg_arg) > SW'(MAX_OFFSET)) st = ST_INVALID;
        else                               st = ST_OK;
      OP_PROTECT:
        if (locked)        st = ST_ACCESS;
        else if (!base_set) st = ST_UNSUP;
        else if (bad_rng)  st = ST_INVALID;
        else if (full)     st = ST_NORES;
        else               st = ST_OK;
      OP_LOCK:
        st = locked ? ST_ALREADY : ST_OK;
      default:
        st = ST_INVALID;
    endcase
  end

  assign rng_we    = acc && (st == ST_OK) && (cfg_op == OP_PROTECT);
  assign rng_clr   = acc && (st == ST_OK) && (cfg_op == OP_CLEAR);
  assign rng_idx   = nxt_q;
  assign rng_start = EW'(cfg_arg[AW-1:BLK_SHIFT]);
  assign rng_end   = EW'(cfg_arg[AW-1:BLK_SHIFT]) + EW'(cfg_count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_status    <= 3'd0;
      locked        <= 1'b0;
      base_set      <= 1'b0;
      base_addr     <= '0;
      erase_set     <= 1'b0;
      erase_opcode  <= 8'd0;
      prefix_opcode <= 8'd0;
      nxt_q         <= '0;
    end else begin
      if (acc) begin
        rsp_valid  <= 1'b1;
        rsp_status <= st;
        if (st == ST_OK) begin
          case (cfg_op)
            OP_ERASE_OP: begin
              erase_opcode <= cfg_arg[7:0];
              erase_set    <= 1'b1;
            end
            OP_PREFIX_OP: prefix_opcode <= cfg_arg[7:0];
            OP_BASE: begin
              base_addr <= cfg_arg;
              base_set  <= 1'b1;
            end
            OP_CLEAR:   nxt_q  <= '0;
            OP_PROTECT: nxt_q  <= nxt_q + 1'b1;
            OP_LOCK:    locked <= 1'b1;
            default: ;
          endcase
        end
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wpr_range_bank.sv
module wpr_range_bank #(
  parameter int unsigned NR = 5,
  parameter int unsigned EW = 21,
  parameter int unsigned IW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IW-1:0]    idx,
  input  logic [EW-1:0]    start,
  input  logic [EW-1:0]    stop,
  input  logic             clr,
  output logic [NR-1:0]    vld,
  output logic [NR*EW-1:0] st_flat,
  output logic [NR*EW-1:0] en_flat
);
  for (genvar i = 0; i < NR; i++) begin : g_slot
    logic          v_q;
    logic [EW-1:0] s_q;
    logic [EW-1:0] e_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        s_q <= '0;
        e_q <= '0;
      end else if (clr) begin
        v_q <= 1'b0;
      end else if (we && (idx == IW'(i))) begin
        v_q <= 1'b1;
        s_q <= start;
        e_q <= stop;
      end
    end

    assign vld[i]              = v_q;
    assign st_flat[i*EW +: EW] = s_q;
    assign en_flat[i*EW +: EW] = e_q;
  end
endmodule

// File: rtl/wpr_point_hit.sv
module wpr_point_hit #(
  parameter int unsigned NR = 5,
  parameter int unsigned EW = 21
) (
  input  logic [EW-1:0]    pt,
  input  logic [NR-1:0]    vld,
  input  logic [NR*EW-1:0] st_flat,
  input  logic [NR*EW-1:0] en_flat,
  output logic             hit
);
  logic [NR-1:0] in_rng;

  for (genvar j = 0; j < NR; j++) begin : g_cmp
    assign in_rng[j] = vld[j] && (pt >= st_flat[j*EW +: EW]) &&
                       (pt < en_flat[j*EW +: EW]);
  end

  assign hit = |in_rng;
endmodule

// File: rtl/wpr_unit.sv
module wpr_unit
  import wpr_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned CW         = 16,
  parameter int unsigned NR         = 5,
  parameter int unsigned MAX_RANGE  = 32'h0100_0000,
  parameter int unsigned MAX_OFFSET = 32'h0100_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_valid,
  output logic          cfg_ready,
  input  logic [2:0]    cfg_op,
  input  logic [AW-1:0] cfg_arg,
  input  logic [CW-1:0] cfg_count,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [2:0]    rsp_status,
  output logic          locked,
  output logic          base_set,
  output logic [AW-1:0] base_addr,
  output logic          erase_set,
  output logic [7:0]    erase_opcode,
  output logic [7:0]    prefix_opcode,
  input  logic [7:0]    chk_opcode,
  input  logic          chk_write,
  input  logic [AW-1:0] chk_addr,
  output logic          chk_block,
  input  logic          q_valid,
  input  logic [AW-1:0] q_addr,
  input  logic [CW-1:0] q_count,
  output logic          q_rsp_valid,
  output logic          q_protected,
  output logic [7:0]    cap_ranges,
  output logic [31:0]   cap_max_range,
  output logic [31:0]   cap_max_offset
);
  localparam int unsigned BW = AW - BLK_SHIFT;
  localparam int unsigned EW = BW + 1;
  localparam int unsigned IW = $clog2(NR + 1);

  logic             rng_we;
  logic             rng_clr;
  logic [IW-1:0]    rng_idx;
  logic [EW-1:0]    rng_start;
  logic [EW-1:0]    rng_end;
  logic [NR-1:0]    vld;
  logic [NR*EW-1:0] st_flat;
  logic [NR*EW-1:0] en_flat;

  assign cap_ranges     = 8'(NR);
  assign cap_max_range  = 32'(MAX_RANGE);
  assign cap_max_offset = 32'(MAX_OFFSET);

  wpr_ctrl #(
    .AW(AW), .CW(CW), .NR(NR), .MAX_RANGE(MAX_RANGE), .MAX_OFFSET(MAX_OFFSET)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_op(cfg_op),
    .cfg_arg(cfg_arg), .cfg_count(cfg_count),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .locked(locked), .base_set(base_set), .base_addr(base_addr),
    .erase_set(erase_set), .erase_opcode(erase_opcode),
    .prefix_opcode(prefix_opcode),
    .rng_we(rng_we), .rng_idx(rng_idx), .rng_start(rng_start),
    .rng_end(rng_end), .rng_clr(rng_clr)
  );

  wpr_range_bank #(.NR(NR), .EW(EW), .IW(IW)) bank_i (
    .clk(clk), .rst_n(rst_n), .we(rng_we), .idx(rng_idx),
    .start(rng_start), .stop(rng_end), .clr(rng_clr),
    .vld(vld), .st_flat(st_flat), .en_flat(en_flat)
  );

  // command check: one point lookup
  logic cmd_hit;
  logic modifying;

  wpr_point_hit #(.NR(NR), .EW(EW)) cmd_hit_i (
    .pt(EW'(chk_addr[AW-1:BLK_SHIFT])), .vld(vld),
    .st_flat(st_flat), .en_flat(en_flat), .hit(cmd_hit)
  );

  assign modifying = chk_write || (erase_set && (chk_opcode == erase_opcode));
  assign chk_block = modifying && cmd_hit;

  // coverage query: the span is covered iff its first block is covered and
  // every range end falling strictly inside the span is itself covered
  logic [EW-1:0] qs;
  logic [EW-1:0] qe;
  logic          head_hit;
  logic [NR-1:0] gap;

  assign qs = EW'(q_addr[AW-1:BLK_SHIFT]);
  assign qe = qs + EW'(q_count);

  wpr_point_hit #(.NR(NR), .EW(EW)) head_i (
    .pt(qs), .vld(vld), .st_flat(st_flat), .en_flat(en_flat), .hit(head_hit)
  );

  for (genvar i = 0; i < NR; i++) begin : g_edge
    logic [EW-1:0] e_pt;
    logic          e_hit;
    assign e_pt = en_flat[i*EW +: EW];
    wpr_point_hit #(.NR(NR), .EW(EW)) edge_i (
      .pt(e_pt), .vld(vld), .st_flat(st_flat), .en_flat(en_flat), .hit(e_hit)
    );
    assign gap[i] = vld[i] && (e_pt > qs) && (e_pt < qe) && !e_hit;
  end

  logic covered;
  assign covered = (q_count != '0) && head_hit && !(|gap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_rsp_valid <= 1'b0;
      q_protected <= 1'b0;
    end else begin
      q_rsp_valid <= q_valid;
      q_protected <= q_valid && covered;
    end
  end

  logic unused_low;
  assign unused_low = ^{chk_addr[BLK_SHIFT-1:0], q_addr[BLK_SHIFT-1:0]};
endmodule

// File: rtl/wpr_unit_chk.sv
module wpr_unit_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_valid,
  input logic          cfg_ready,
  input logic [2:0]    cfg_op,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [2:0]    rsp_status,
  input logic          locked,
  input logic          base_set,
  input logic [AW-1:0] base_addr,
  input logic          erase_set,
  input logic [7:0]    erase_opcode,
  input logic [7:0]    prefix_opcode,
  input logic [7:0]    chk_opcode,
  input logic          chk_write,
  input logic          chk_block,
  input logic          q_valid,
  input logic [CW-1:0] q_count,
  input logic          q_rsp_valid,
  input logic          q_protected
);
  p_rsp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status));

  p_accept_answer_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_ready |=> rsp_valid);

  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  p_relock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_ready && cfg_op == 3'd5 && locked |=> rsp_status == 3'd5);

  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(erase_opcode) && $stable(prefix_opcode) &&
               $stable(base_addr) && $stable(erase_set));

  p_base_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    base_set |=> base_set && $stable(base_addr));

  p_early_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_ready && cfg_op == 3'd4 && !locked && !base_set
    |=> rsp_status == 3'd3);

  p_read_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_write && !(erase_set && chk_opcode == erase_opcode) |-> !chk_block);

  p_query_lat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> q_rsp_valid);

  p_empty_query_r12: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && q_count == '0 |=> !q_protected);
endmodule

bind wpr_unit wpr_unit_chk #(.AW(AW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
  .cfg_op(cfg_op), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_status(rsp_status), .locked(locked), .base_set(base_set),
  .base_addr(base_addr), .erase_set(erase_set), .erase_opcode(erase_opcode),
  .prefix_opcode(prefix_opcode), .chk_opcode(chk_opcode),
  .chk_write(chk_write), .chk_block(chk_block), .q_valid(q_valid),
  .q_count(q_count), .q_rsp_valid(q_rsp_valid), .q_protected(q_protected)
);

// File: tb/wpr_unit_tb_top.sv
`timescale 1ns/1ps
module wpr_unit_tb_top;
  localparam int AW = 32;
  localparam int CW = 8;
  localparam int NR = 3;
  localparam longint MAXR = 64'h1_0000;
  localparam longint MAXO = 64'h10_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_valid = 1'b0;
  logic          cfg_ready;
  logic [2:0]    cfg_op = '0;
  logic [AW-1:0] cfg_arg = '0;
  logic [CW-1:0] cfg_count = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [2:0]    rsp_status;
  logic          locked, base_set, erase_set;
  logic [AW-1:0] base_addr;
  logic [7:0]    erase_opcode, prefix_opcode;
  logic [7:0]    chk_opcode = 8'h03;
  logic          chk_write = 1'b0;
  logic [AW-1:0] chk_addr = '0;
  logic          chk_block;
  logic          q_valid = 1'b0;
  logic [AW-1:0] q_addr = '0;
  logic [CW-1:0] q_count = '0;
  logic          q_rsp_valid, q_protected;
  logic [7:0]    cap_ranges;
  logic [31:0]   cap_max_range, cap_max_offset;

  always #2 clk = ~clk;

  wpr_unit #(.AW(AW), .CW(CW), .NR(NR), .MAX_RANGE(32'h1_0000),
             .MAX_OFFSET(32'h10_0000)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_op(cfg_op), .cfg_arg(cfg_arg), .cfg_count(cfg_count),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .locked(locked), .base_set(base_set), .base_addr(base_addr),
    .erase_set(erase_set), .erase_opcode(erase_opcode),
    .prefix_opcode(prefix_opcode), .chk_opcode(chk_opcode),
    .chk_write(chk_write), .chk_addr(chk_addr), .chk_block(chk_block),
    .q_valid(q_valid), .q_addr(q_addr), .q_count(q_count),
    .q_rsp_valid(q_rsp_valid), .q_protected(q_protected),
    .cap_ranges(cap_ranges), .cap_max_range(cap_max_range),
    .cap_max_offset(cap_max_offset)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench-side model of the range set
  longint m_st[NR];
  longint m_en[NR];
  bit     m_v[NR];
  int     m_n = 0;
  longint m_base = 0;
  bit     m_base_set = 0;
  bit     m_lock = 0;
  bit     m_erase_set = 0;
  int     m_erase = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_cfg(input int op, input longint arg, input int cnt,
                        input int exp, input string tag);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_op = op[2:0]; cfg_arg = arg[AW-1:0];
    cfg_count = cnt[CW-1:0]; rsp_ready = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
    check({tag, " rsp_valid"}, rsp_valid, 1);
    check({tag, " status"}, rsp_status, exp);
  endtask

  function automatic bit m_hit(input longint blk);
    for (int i = 0; i < NR; i++)
      if (m_v[i] && blk >= m_st[i] && blk < m_en[i]) return 1;
    return 0;
  endfunction

  function automatic bit m_cover(input longint s, input int c);
    if (c == 0) return 0;
    for (longint b = s; b < s + c; b++) if (!m_hit(b)) return 0;
    return 1;
  endfunction

  // R6 R7 R8 R4: compute the allocation answer and update the model
  task automatic alloc(input longint addr, input int cnt);
    int exp;
    if (m_lock) exp = 1;
    else if (!m_base_set) exp = 3;
    else if (addr < m_base || cnt * 4096 > MAXR ||
             addr - m_base + cnt * 4096 > MAXR) exp = 2;
    else if (m_n == NR) exp = 4;
    else exp = 0;
    do_cfg(4, addr, cnt, exp, "R7 R8 alloc");
    if (exp == 0) begin
      m_v[m_n] = 1; m_st[m_n] = addr >> 12; m_en[m_n] = (addr >> 12) + cnt;
      m_n++;
    end
  endtask

  // R10 R11: command check sweep over blocks
  task automatic chk_sweep(input string tag);
    for (int b = 0; b < 48; b++) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk_addr = AW'((longint'(b) << 12) | 64'hABC);
        chk_write = (k == 0);
        chk_opcode = (k == 2) ? 8'hD8 : 8'h03;
        #1;
        if (k == 1) check({tag, " R11 read"}, chk_block, 0);
        else check({tag, " R10 block"}, chk_block,
                   m_hit(b) && (k == 0 || (m_erase_set && m_erase == 8'hD8)));
      end
    end
    chk_write = 1'b0;
  endtask

  // R12: coverage query sweep
  task automatic q_sweep(input string tag);
    for (int s = 14; s < 27; s++) begin
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        q_valid = 1'b1; q_addr = AW'((longint'(s) << 12) | 64'h123);
        q_count = c[CW-1:0];
        @(negedge clk);
        q_valid = 1'b0;
        check({tag, " R12 qvalid"}, q_rsp_valid, 1);
        check({tag, " R12 cover"}, q_protected, m_cover(s, c));
      end
    end
  endtask

  initial begin
    for (int i = 0; i < NR; i++) begin m_v[i] = 0; m_st[i] = 0; m_en[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14 reset state, R13 capabilities
    check("R14 rsp_valid", rsp_valid, 0);
    check("R14 cfg_ready", cfg_ready, 1);
    check("R14 locked", locked, 0);
    check("R14 base_set", base_set, 0);
    check("R14 q_rsp_valid", q_rsp_valid, 0);
    chk_write = 1'b1; chk_addr = 32'h0; #1;
    check("R14 no range", chk_block, 0);
    chk_write = 1'b0;
    check("R13 ranges", cap_ranges, NR);
    check("R13 max range", cap_max_range, MAXR);
    check("R13 max offset", cap_max_offset, MAXO);

    alloc(64'h10000, 1);                       // R6
    do_cfg(6, 0, 0, 2, "R2 op6");
    do_cfg(7, 0, 0, 2, "R2 op7");
    do_cfg(2, 64'h20_0000, 0, 2, "R5 base too high");
    check("R5 base unset", base_set, 0);
    do_cfg(2, 64'h10000, 0, 0, "R5 base");
    m_base = 64'h10000; m_base_set = 1;
    check("R5 base_addr", base_addr, 64'h10000);
    do_cfg(2, 64'h20000, 0, 3, "R5 base twice");
    check("R5 base kept", base_addr, 64'h10000);
    do_cfg(0, 64'hD8, 0, 0, "R2 erase op");
    m_erase_set = 1; m_erase = 8'hD8;
    check("R2 erase value", erase_opcode, 8'hD8);
    do_cfg(1, 64'h50, 0, 0, "R2 prefix op");
    check("R2 prefix value", prefix_opcode, 8'h50);

    // R7 R8 grid of start addresses and counts
    begin
      longint addrs[6] = '{64'hF000, 64'h10000, 64'h18000, 64'h1F000,
                           64'h20000, 64'h1_0800};
      int cnts[5] = '{0, 1, 8, 16, 17};
      foreach (addrs[i]) foreach (cnts[j]) alloc(addrs[i], cnts[j]);
    end
    chk_sweep("grid");
    q_sweep("grid");

    // R9 wipe
    do_cfg(3, 0, 0, 0, "R9 clear");
    for (int i = 0; i < NR; i++) m_v[i] = 0;
    m_n = 0;
    chk_sweep("R9 after clear");

    alloc(64'h10800, 4);
    alloc(64'h14000, 2);
    alloc(64'h18fff, 2);
    alloc(64'h1A000, 1);                       // R8 full
    chk_sweep("set");
    q_sweep("set");

    // R1 back-pressure
    @(negedge clk);
    cfg_valid = 1'b1; cfg_op = 3'd0; cfg_arg = 32'hD8; rsp_ready = 1'b0;
    @(negedge clk);
    cfg_valid = 1'b0;
    check("R1 rsp up", rsp_valid, 1);
    check("R1 ready low", cfg_ready, 0);
    @(negedge clk);
    check("R1 rsp held", rsp_valid, 1);
    check("R1 status held", rsp_status, 0);
    check("R1 still stalled", cfg_ready, 0);
    rsp_ready = 1'b1;
    #1;
    check("R1 ready follows", cfg_ready, 1);
    @(negedge clk);
    check("R1 rsp drained", rsp_valid, 0);

    // R3 R4 lock
    do_cfg(5, 0, 0, 0, "R3 lock");
    m_lock = 1;
    check("R3 locked", locked, 1);
    do_cfg(5, 0, 0, 5, "R3 relock");
    check("R3 still locked", locked, 1);
    do_cfg(0, 64'h20, 0, 1, "R4 erase");
    do_cfg(1, 64'h06, 0, 1, "R4 prefix");
    do_cfg(2, 64'h0, 0, 1, "R4 base");
    do_cfg(3, 0, 0, 1, "R4 clear");
    alloc(64'h1C000, 1);
    check("R4 erase kept", erase_opcode, 8'hD8);
    check("R4 prefix kept", prefix_opcode, 8'h50);
    check("R4 base kept", base_addr, 64'h10000);
    chk_sweep("R4 locked");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule